// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block picks single operations out of a stream of retiring operations (or micro-ops) so that a separate capture stage can profile them in detail. Every operation offered on the valid strobe moves a down-counter one step closer to the next selection. When the counter runs out, the operation that used it up is chosen, a one-cycle tag pulse goes out, and the counter is reloaded. The reload value is the programmed interval, raised to a built-in minimum when the programmed value is smaller, including the unprogrammed value zero. Software can add a pseudo-random offset to each reload, so that sampling does not fall into step with loops in the code being profiled.

Only one chosen operation may be open at a time. A busy flag is raised with the tag and lowered after the capture stage reports completion. If the counter runs out while the flag is still raised, nothing is tagged. That event is a collision, and a saturating counter, which software can clear, records it. Collisions are counted before any later record filter, so the count covers every dropped selection.

Top module: `op_sample_selector`

## Requirements
- R1: While reset is low and on the first cycle after it is released, sample_tag and busy are 0, coll_count is 0 and count_left equals MIN_IVAL.
- R2: Each clock edge with op_valid high and count_left above 1 lowers count_left by exactly 1. An edge with op_valid low leaves count_left unchanged.
- R3: An edge with op_valid high and count_left equal to 1 is a selection. After that edge count_left holds the reload value. If busy was 0 before the edge, sample_tag is 1 for exactly the one following cycle.
- R4: With jitter off, the reload value is cfg_interval when cfg_interval is at least MIN_IVAL, and MIN_IVAL otherwise (zero meaning unprogrammed).
- R5: With cfg_jitter_en high, the reload value is the R4 value plus the low JIT_W bits of a 16-bit LFSR. At reset the LFSR holds 16'hACE1. On every selection (collision or not, jitter on or off) it advances once: it shifts right by one, and when the bit shifted out is 1 the result is XORed with 16'hB400. The offset uses the LFSR value from before the advance.
- R6: busy rises in the same cycle as sample_tag. An edge with busy and op_done high clears busy for the next cycle, so a selection on that following edge is tagged. op_done while busy is 0 has no effect.
- R7: A selection at an edge where busy is 1 (even if op_done is also high) produces no sample_tag. It increments coll_count by 1 and still reloads count_left.
- R8: coll_count saturates at all ones (2^COLL_W-1) and stays there on further collisions.
- R9: An edge with coll_clr high sets coll_count to 0, even if a collision happens at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One population operation offered this cycle |
| op_done | input | 1 | Capture of the open sampled operation has finished |
| cfg_interval | input | CNT_W | Programmed sampling interval; 0 means not programmed |
| cfg_jitter_en | input | 1 | Add the pseudo-random offset to each reload |
| coll_clr | input | 1 | Clear the collision counter |
| sample_tag | output | 1 | One-cycle pulse: the last accepted operation is sampled |
| busy | output | 1 | A sampled operation is open |
| count_left | output | CNT_W+1 | Operations remaining until the next selection |
| coll_count | output | COLL_W | Saturating count of dropped selections |
| min_interval | output | CNT_W | Built-in minimum interval |

## Verification
Every result is registered once. An operation, completion or clear driven before clock edge k shows on count_left, sample_tag, busy and coll_count right after edge k, and nowhere later. The bench changes inputs on the falling edge and compares all four outputs one nanosecond after each rising edge with a cycle model that it advances by one step per edge. Sweeps over several intervals (below, at and above the minimum), completion latencies from zero to never, and jitter on and off cover both tagged selections and collisions. A narrow collision counter in the bench makes saturation, and a clear at the same edge as a collision, reachable in a short run.

// File: rtl/sel_pkg.sv
// Package sel_pkg
// Shared constants and helpers for the operation sampling selector.
// Assumes LFSR widths of at least 2 bits.
package sel_pkg;

    // Reset seed and feedback mask of the 16-bit perturbation LFSR
    localparam int unsigned LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] LFSR_MASK = 16'hB400;

    // One right-shift Galois step of the perturbation LFSR
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? LFSR_MASK : 16'h0000);
    endfunction

endpackage

// File: rtl/sel_lfsr.sv
// Module sel_lfsr
// Holds the perturbation LFSR and advances it once per selection.
// Exposes only the low OUT_W bits, which form the reload offset.
// Assumes OUT_W <= 16.
module sel_lfsr #(
    parameter int unsigned OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] jit
);
    import sel_pkg::*;

    logic [LFSR_W-1:0] state;

    // Seed at reset, step on each selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LFSR_SEED;
        end else if (adv) begin
            state <= lfsr_step(state);
        end
    end

    // Offset taken from the pre-advance state
    assign jit = state[OUT_W-1:0];

endmodule

// File: rtl/sel_interval_counter.sv
// Module sel_interval_counter
// Counts population operations down to the next selection and reloads.
// Reload is max(cfg, MIN_IVAL), plus an optional offset when jitter is on.
// Assumes MIN_IVAL >= 1 and JIT_W <= CNT_W so the sum fits CNT_W+1 bits.
module sel_interval_counter #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned JIT_W    = 8,
    parameter int unsigned MIN_IVAL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             jit_en,
    input  logic [JIT_W-1:0] jit_val,
    output logic             expire,
    output logic [CNT_W:0]   count_left
);
    localparam int unsigned RW = CNT_W + 1;
    localparam logic [CNT_W-1:0] MIN_V = MIN_IVAL[CNT_W-1:0];
    localparam logic [RW-1:0]    ONE   = RW'(1);

    logic [CNT_W-1:0] base_ival;
    logic [RW-1:0]    jit_ext;
    logic [RW-1:0]    reload_val;
    logic [RW-1:0]    cnt_q;

    // Clamp the programmed interval to the minimum
    always_comb begin
        base_ival = (cfg_interval < MIN_V) ? MIN_V : cfg_interval;
    end

    // Offset path: present only when a jitter width is configured
    generate
        if (JIT_W > 0) begin : g_jit
            always_comb jit_ext = jit_en ? RW'(jit_val) : '0;
        end else begin : g_nojit
            logic unused_jit;
            always_comb unused_jit = jit_en ^ (^jit_val);
            always_comb jit_ext = '0;
        end
    endgenerate

    // Sum of clamped interval and offset
    always_comb begin
        reload_val = RW'(base_ival) + jit_ext;
    end

    assign expire = op_valid && (cnt_q == ONE);

    // Decrement per operation, reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RW'(MIN_V);
        end else if (expire) begin
            cnt_q <= reload_val;
        end else if (op_valid) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count_left = cnt_q;

endmodule

// File: rtl/sel_inflight.sv
// Module sel_inflight
// Tracks the single open sampled operation and issues the tag pulse.
// A selection while open becomes a collision; completion frees the slot
// for the next edge. Assumes op_done is only meaningful while busy.
module sel_inflight (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic op_done,
    output logic sample_tag,
    output logic busy,
    output logic collide
);
    logic take;

    // Split a selection into accepted or collided
    always_comb begin
        take    = expire && !busy;
        collide = expire && busy;
    end

    // Tag pulse and open flag, both set by an accepted selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_tag <= 1'b0;
            busy       <= 1'b0;
        end else begin
            sample_tag <= take;
            if (take) begin
                busy <= 1'b1;
            end else if (op_done) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sel_sat_counter.sv
// Module sel_sat_counter
// Saturating event counter with a synchronous clear that wins over inc.
module sel_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    // Count up to all ones, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (inc && value != TOP) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/op_sample_selector.sv
// Module op_sample_selector
// Top of the operation sampling selector: interval counter, perturbation
// LFSR, in-flight tracker and collision counter.
// Assumes one population operation per cycle at most and that the
// capture stage raises op_done once per tagged operation.
module op_sample_selector #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned JIT_W    = 8,
    parameter int unsigned MIN_IVAL = 8,
    parameter int unsigned COLL_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_done,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              cfg_jitter_en,
    input  logic              coll_clr,
    output logic              sample_tag,
    output logic              busy,
    output logic [CNT_W:0]    count_left,
    output logic [COLL_W-1:0] coll_count,
    output logic [CNT_W-1:0]  min_interval
);
    logic             expire;
    logic             collide;
    logic [JIT_W-1:0] jit_val;

    // Offset source, stepped on every selection
    sel_lfsr #(.OUT_W(JIT_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (expire),
        .jit   (jit_val)
    );

    // Down-counter to the next selection
    sel_interval_counter #(
        .CNT_W    (CNT_W),
        .JIT_W    (JIT_W),
        .MIN_IVAL (MIN_IVAL)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .cfg_interval (cfg_interval),
        .jit_en       (cfg_jitter_en),
        .jit_val      (jit_val),
        .expire       (expire),
        .count_left   (count_left)
    );

    // Single open sample slot
    sel_inflight u_fly (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .op_done    (op_done),
        .sample_tag (sample_tag),
        .busy       (busy),
        .collide    (collide)
    );

    // Dropped-selection counter
    sel_sat_counter #(.W(COLL_W)) u_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (collide),
        .clr   (coll_clr),
        .value (coll_count)
    );

    assign min_interval = MIN_IVAL[CNT_W-1:0];

endmodule

// File: rtl/sel_checker.sv
// Module sel_checker
// Temporal checks on the selector's ports, bound into every instance.
module sel_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned COLL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_done,
    input logic              coll_clr,
    input logic              sample_tag,
    input logic              busy,
    input logic [CNT_W:0]    count_left,
    input logic [COLL_W-1:0] coll_count
);
    localparam logic [COLL_W-1:0] CTOP = '1;

    // R3
    tag_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tag |-> busy);

    // R3
    tag_needs_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tag |-> !$past(busy));

    // R2
    idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> $stable(count_left));

    // R2
    count_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_left != '0);

    // R6
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(op_done)) |-> busy);

    // R7
    coll_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(coll_clr)) |-> (coll_count >= $past(coll_count)));

    // R8
    coll_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(coll_clr) && $past(coll_count) == CTOP) |-> coll_count == CTOP);

    // R9
    coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(coll_clr)) |-> coll_count == '0);

endmodule

bind op_sample_selector sel_checker #(.CNT_W(CNT_W), .COLL_W(COLL_W)) u_sel_chk (.*);

// File: tb/tb_op_sample_selector.sv
`timescale 1ns/1ps
module tb_op_sample_selector;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned JIT_W  = 8;
    localparam int unsigned MINI   = 3;
    localparam int unsigned COLL_W = 4;
    localparam int unsigned CMAX   = (1 << COLL_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic              op_done = 1'b0;
    logic [CNT_W-1:0]  cfg_interval = '0;
    logic              cfg_jitter_en = 1'b0;
    logic              coll_clr = 1'b0;
    logic              sample_tag;
    logic              busy;
    logic [CNT_W:0]    count_left;
    logic [COLL_W-1:0] coll_count;
    logic [CNT_W-1:0]  min_interval;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int          m_cnt, m_coll, m_age;
    logic        m_busy, m_tag;
    logic [15:0] m_lfsr;
    string       lbl_cnt, lbl_coll, lbl_tag;

    op_sample_selector #(
        .CNT_W(CNT_W), .JIT_W(JIT_W), .MIN_IVAL(MINI), .COLL_W(COLL_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_done(op_done),
        .cfg_interval(cfg_interval), .cfg_jitter_en(cfg_jitter_en),
        .coll_clr(coll_clr), .sample_tag(sample_tag), .busy(busy),
        .count_left(count_left), .coll_count(coll_count),
        .min_interval(min_interval)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = MINI; m_coll = 0; m_busy = 1'b0; m_tag = 1'b0;
        m_lfsr = 16'hACE1; m_age = 0;
    endtask

    task automatic check_all();
        check(lbl_cnt, count_left, m_cnt);
        check(lbl_tag, sample_tag, m_tag);
        check("R6 busy", busy, m_busy);
        check(lbl_coll, coll_count, m_coll);
    endtask

    // one clock: drive at falling edge, advance model at rising edge, check after
    task automatic step(input logic v, input logic d, input logic clr);
        logic expire;
        int   base;
        @(negedge clk);
        op_valid = v; op_done = d; coll_clr = clr;
        @(posedge clk);
        expire = v && (m_cnt == 1);
        base = (int'(cfg_interval) < MINI) ? MINI : int'(cfg_interval);
        lbl_cnt = "R2 count"; lbl_tag = "R3 tag"; lbl_coll = "R7 coll";
        m_tag = expire && !m_busy;
        if (expire && m_busy) begin
            lbl_tag = "R7 no-tag";
            if (m_coll < CMAX) m_coll++;
        end
        if (m_coll == CMAX) lbl_coll = "R8 coll";
        if (clr) begin m_coll = 0; lbl_coll = "R9 coll"; end
        if (m_tag) m_busy = 1'b1;
        else if (d) m_busy = 1'b0;
        if (expire) begin
            m_cnt = base + (cfg_jitter_en ? int'(m_lfsr[7:0]) : 0);
            lbl_cnt = cfg_jitter_en ? "R5 reload" :
                      (int'(cfg_interval) < MINI ? "R4 reload" : "R3 reload");
            m_lfsr = {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
        end else if (v) begin
            m_cnt--;
        end
        if (m_tag) m_age = 0;
        else if (m_busy) m_age++;
        #1;
        check_all();
    endtask

    // run a traffic pattern with completion latency lat (<0 = never)
    task automatic run(input int cycles, input int lat, input int seed);
        for (int c = 0; c < cycles; c++) begin
            logic v, d;
            v = ((c * 7 + seed) % 3) != 0;
            d = m_busy && (lat >= 0) && (m_age >= lat);
            step(v, d, 1'b0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; op_done = 1'b0; coll_clr = 1'b0;
        @(posedge clk); #1;
        model_reset();
        check("R1 tag", sample_tag, 0);
        check("R1 busy", busy, 0);
        check("R1 coll", coll_count, 0);
        check("R1 count", count_left, MINI);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 count after release", count_left, MINI);
        check("R1 busy after release", busy, 0);
    endtask

    initial begin
        int ivals[6];
        int lats[5];
        ivals = '{0, 1, 2, 3, 4, 7};
        lats  = '{0, 1, 2, 5, 9};
        model_reset();
        repeat (2) @(posedge clk);
        do_reset();
        check("R4 min_interval port", min_interval, MINI);

        // jitter off: interval and latency sweep
        foreach (ivals[i]) begin
            foreach (lats[j]) begin
                cfg_interval = CNT_W'(ivals[i]);
                run(30, lats[j], i + j);
            end
        end

        // done while idle has no effect
        step(1'b0, 1'b1, 1'b0);

        // jitter on
        cfg_jitter_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cfg_interval = (k % 2 == 0) ? CNT_W'(0) : CNT_W'(5);
            run(300, (k < 2) ? 0 : ((k < 4) ? 3 : 40), k);
        end
        cfg_jitter_en = 1'b0;

        // collisions to saturation
        do_reset();
        cfg_interval = '0;
        for (int c = 0; c < 90; c++) step(1'b1, 1'b0, 1'b0);
        check("R8 saturated", coll_count, CMAX);
        // clear while collisions keep arriving
        for (int c = 0; c < 6; c++) step(1'b1, 1'b0, 1'b1);
        check("R9 cleared", coll_count, 0);
        for (int c = 0; c < 9; c++) step(1'b1, 1'b0, 1'b0);
        // done and collision on the same edge, then a tagged selection
        for (int c = 0; c < 12; c++) step(1'b1, (m_cnt == 1), 1'b0);
        run(40, 1, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule